// File: doc/BRIEF.md
# Lockable Dual Alarm Comparator

This block watches a running day, hour, minute and second count supplied from outside and compares it against two alarm settings. The primary alarm is slow to change: a host write goes into a staging register and is committed only after a programmable number of cycles, with a completion flag raised when each field lands. The secondary alarm is written directly and takes effect on the next cycle. A match is looked for only on cycles where the time source pulses its tick strobe.

Each alarm match latches a status bit that stays set until the host clears it with a write-one-to-clear access. Status is masked by an enable register to form an interrupt line and a wake line. Either alarm may wake the system, but only the primary alarm may drive the power-up line, and only while a committed 8-bit key holds the open value. The key shares a register with a sticky power-off alarm flag. The key, the flag and the committed primary alarm sit in an always-on domain that is reset by a separate power-on reset and keeps its contents through a host reset.

Top module: `alarm_pair_cmp`

## Requirements
- R1: After power-on and host reset, the enable, raw status, secondary alarm, committed primary alarm and key register all read 0, and `irq`, `wake` and `pwr_up` are low.
- R2: A write to 0x20, 0x24, 0x28 or 0x2C (second, minute, hour, day) loads staging only. Readback at 0x40, 0x44, 0x48 or 0x4C keeps the old value until the rising edge COMMIT_DLY cycles after the write edge. At that edge the new value appears and raw status bit 12, 13, 14 or 15 sets.
- R3: A write to 0x60, 0x64, 0x68 or 0x6C (second, minute, hour, day) is readable at the same offset from the next cycle and sets no raw status bit.
- R4: On a cycle with `tick` high where the time equals the committed primary alarm, raw bit 4 sets at the next edge. Where the time equals the secondary alarm, raw bit 6 sets. Equal time with `tick` low sets nothing.
- R5: Raw status bits are sticky. A write to 0x38 clears exactly the bits written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R6: Register 0x30 holds the enable bits (read/write), 0x34 reads raw status, and 0x3C reads raw AND enable. `irq` is high exactly when raw AND enable is nonzero.
- R7: `wake` is high when raw bit 4 with enable bit 4, or raw bit 6 with enable bit 6, is set. `pwr_up` is high only when raw bit 4 and enable bit 4 are set and the committed key byte is 0xA5. The secondary alarm never raises `pwr_up`.
- R8: A write to 0x54 stages bits 8:0 (bit 8 is the power-off alarm flag, bits 7:0 the key). The write commits after COMMIT_DLY cycles, is read at 0x50, and sets raw bit 7 when it commits. Writing 0x5A closes the key.
- R9: A host reset alone leaves the committed key, the flag and the committed primary alarm unchanged, and clears the enable, status and secondary alarm.
- R10: A new staged write before a pending commit completes restarts the delay. Only the newest value is committed, COMMIT_DLY cycles after the newest write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low host reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the always-on state |
| tick | input | 1 | One-cycle strobe marking a new time value |
| now_sec | input | 6 | Current second |
| now_min | input | 6 | Current minute |
| now_hour | input | 5 | Current hour |
| now_day | input | 16 | Current day count |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of enabled raw status |
| wake | output | 1 | Enabled alarm match from either alarm |
| pwr_up | output | 1 | Enabled primary alarm match with the key open |

## Verification
The bench reads the committed primary alarm every cycle across the commit window. A commit that lands one cycle early or late therefore shows up as a readback mismatch at the boundary. It rewrites a field mid-commit to catch a design that lets the first value land or fails to restart its timer. It pulses `tick` in the same cycle as a clear write, so a clear-wins design loses the status bit. It also holds a matching time with `tick` low to catch a comparator that is not gated by the strobe. The bench closes the key and then matches again: `pwr_up` must stay low while `wake` rises. Finally it pulls only the host reset, to catch a design that places the key, the flag or the committed alarm in the host domain.

// File: rtl/alarm_pkg.sv
// Package: shared widths, register offsets, status bit positions and key
// values for the dual alarm comparator.
package alarm_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 16;
    localparam int TIME_W = SEC_W + MIN_W + HOUR_W + DAY_W;
    localparam int REG_W  = 16;
    localparam int KEY_W  = 8;
    localparam int LOCK_W = KEY_W + 1;
    localparam int NFLD   = 4;

    localparam logic [7:0] OFF_NSTAGE = 8'h20;
    localparam logic [7:0] OFF_EN     = 8'h30;
    localparam logic [7:0] OFF_RAW    = 8'h34;
    localparam logic [7:0] OFF_CLR    = 8'h38;
    localparam logic [7:0] OFF_MSK    = 8'h3C;
    localparam logic [7:0] OFF_NCMT   = 8'h40;
    localparam logic [7:0] OFF_LOCK_R = 8'h50;
    localparam logic [7:0] OFF_LOCK_W = 8'h54;
    localparam logic [7:0] OFF_AUX    = 8'h60;

    localparam int BIT_NHIT  = 4;
    localparam int BIT_AHIT  = 6;
    localparam int BIT_LOCK  = 7;
    localparam int BIT_FDONE = 12;

    localparam logic [KEY_W-1:0] KEY_OPEN = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_SHUT = 8'h5A;

    // Width of time field i (0 second, 1 minute, 2 hour, 3 day).
    function automatic int fld_w(input int i);
        case (i)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return HOUR_W;
            default: return DAY_W;
        endcase
    endfunction

    // Position of time field i inside the packed {day,hour,min,sec} vector.
    function automatic int fld_lsb(input int i);
        case (i)
            0:       return 0;
            1:       return SEC_W;
            2:       return SEC_W + MIN_W;
            default: return SEC_W + MIN_W + HOUR_W;
        endcase
    endfunction
endpackage

// File: rtl/staged_commit.sv
// Module: staged_commit
// Holds a host-written value in a staging register and copies it into an
// always-on register DLY cycles after the last write, pulsing done at that
// edge. Assumes DLY >= 1. The staging side is host-reset; the committed value
// is cleared only by the power-on reset, and no commit happens in host reset.
module staged_commit #(
    parameter int W   = 8,
    parameter int DLY = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         por_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         done
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  stage_q;
    logic [W-1:0]  val_q;

    assign done  = rst_n && (cnt_q == CW'(1));
    assign value = val_q;

    // Capture a new staged value and (re)start the commit countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stage_q <= '0;
        end else if (wr) begin
            cnt_q   <= CW'(DLY);
            stage_q <= wdata;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - CW'(1);
        end
    end

    // Move the staged value into the always-on register when the count expires.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            val_q <= '0;
        end else if (done) begin
            val_q <= stage_q;
        end
    end
endmodule

// File: rtl/alarm_match.sv
// Module: alarm_match
// Flags a hit on a tick cycle where the packed time equals the target.
// Purely combinational; the caller latches the result.
module alarm_match #(
    parameter int TW = 33
) (
    input  logic          tick,
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] target,
    output logic          hit
);
    // Equality compare gated by the time strobe.
    always_comb begin
        hit = tick && (now == target);
    end
endmodule

// File: rtl/irq_status.sv
// Module: irq_status
// Enable register and sticky raw status with write-one-to-clear. A set
// request in the same cycle as a clear of that bit leaves it set.
module irq_status #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] en
);
    logic [N-1:0] raw_q;
    logic [N-1:0] en_q;
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;
    assign raw      = raw_q;
    assign en       = en_q;

    // Host-writable enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Sticky status: clear selected bits, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else raw_q <= (raw_q & ~clr_mask) | set;
    end
endmodule

// File: rtl/alarm_pair_cmp.sv
// Module: alarm_pair_cmp (top)
// Compares the supplied time against a slow-commit primary alarm and an
// immediate secondary alarm, latches match and commit events in a status
// register, and drives interrupt, wake and key-gated power-up outputs.
// Assumes the time inputs change only with tick and that por_n is asserted
// together with rst_n at power-on.
module alarm_pair_cmp
    import alarm_pkg::*;
#(
    parameter int COMMIT_DLY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [DAY_W-1:0]  now_day,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              wake,
    output logic              pwr_up
);
    wire  [TIME_W-1:0] now_vec;
    wire  [TIME_W-1:0] norm_vec;
    wire  [TIME_W-1:0] aux_vec;
    wire  [REG_W-1:0]  norm_rd [NFLD];
    wire  [REG_W-1:0]  aux_rd  [NFLD];
    wire  [TIME_W-1:0] tgt     [2];
    logic [NFLD-1:0]   fld_done;
    logic [1:0]        hits;
    logic              lock_done;
    logic [LOCK_W-1:0] lock_val;
    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  raw_q;
    logic [REG_W-1:0]  en_q;
    logic              key_open;

    assign now_vec = {now_day, now_hour, now_min, now_sec};
    assign tgt[0]  = norm_vec;
    assign tgt[1]  = aux_vec;

    // Per-field primary staging/commit and secondary direct register.
    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        localparam int W = fld_w(i);
        localparam int L = fld_lsb(i);
        logic         nwr;
        logic         awr;
        logic [W-1:0] aux_q;

        assign nwr = bus_we && (bus_addr == OFF_NSTAGE + 8'(4 * i));
        assign awr = bus_we && (bus_addr == OFF_AUX + 8'(4 * i));

        staged_commit #(.W(W), .DLY(COMMIT_DLY)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .por_n (por_n),
            .wr    (nwr),
            .wdata (bus_wdata[W-1:0]),
            .value (norm_vec[L +: W]),
            .done  (fld_done[i])
        );

        // Secondary alarm field takes the written value directly.
        always_ff @(posedge clk) begin
            if (!rst_n) aux_q <= '0;
            else if (awr) aux_q <= bus_wdata[W-1:0];
        end

        assign aux_vec[L +: W] = aux_q;
        assign norm_rd[i]      = REG_W'(norm_vec[L +: W]);
        assign aux_rd[i]       = REG_W'(aux_q);
    end

    // Key and power-off flag share one slow-commit register.
    staged_commit #(.W(LOCK_W), .DLY(COMMIT_DLY)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .por_n (por_n),
        .wr    (bus_we && (bus_addr == OFF_LOCK_W)),
        .wdata (bus_wdata[LOCK_W-1:0]),
        .value (lock_val),
        .done  (lock_done)
    );

    // One comparator per alarm group: index 0 primary, 1 secondary.
    for (genvar a = 0; a < 2; a++) begin : g_cmp
        alarm_match #(.TW(TIME_W)) u_match (
            .tick   (tick),
            .now    (now_vec),
            .target (tgt[a]),
            .hit    (hits[a])
        );
    end

    // Gather the status events into their bit positions.
    always_comb begin
        set_vec = '0;
        set_vec[BIT_NHIT] = hits[0];
        set_vec[BIT_AHIT] = hits[1];
        set_vec[BIT_LOCK] = lock_done;
        set_vec[BIT_FDONE +: NFLD] = fld_done;
    end

    irq_status #(.N(REG_W)) u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (set_vec),
        .clr_we (bus_we && (bus_addr == OFF_CLR)),
        .en_we  (bus_we && (bus_addr == OFF_EN)),
        .wdata  (bus_wdata),
        .raw    (raw_q),
        .en     (en_q)
    );

    // Output lines from enabled status and the committed key.
    assign key_open = (lock_val[KEY_W-1:0] == KEY_OPEN);
    assign irq      = |(raw_q & en_q);
    assign wake     = (raw_q[BIT_NHIT] && en_q[BIT_NHIT]) ||
                      (raw_q[BIT_AHIT] && en_q[BIT_AHIT]);
    assign pwr_up   = raw_q[BIT_NHIT] && en_q[BIT_NHIT] && key_open;

    // Register readback decode.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr[7:4] == OFF_NCMT[7:4]) bus_rdata = norm_rd[bus_addr[3:2]];
            else if (bus_addr[7:4] == OFF_AUX[7:4]) bus_rdata = aux_rd[bus_addr[3:2]];
            else if (bus_addr == OFF_EN) bus_rdata = en_q;
            else if (bus_addr == OFF_RAW) bus_rdata = raw_q;
            else if (bus_addr == OFF_MSK) bus_rdata = raw_q & en_q;
            else if (bus_addr == OFF_LOCK_R) bus_rdata = REG_W'(lock_val);
        end
    end
endmodule

// File: rtl/alarm_pair_chk.sv
// Module: alarm_pair_chk
// Property checker bound into alarm_pair_cmp.
module alarm_pair_chk
    import alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              tick,
    input logic [TIME_W-1:0] now_vec,
    input logic [TIME_W-1:0] norm_vec,
    input logic [TIME_W-1:0] aux_vec,
    input logic [REG_W-1:0]  raw_q,
    input logic [LOCK_W-1:0] lock_val,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              irq,
    input logic              wake,
    input logic              pwr_up
);
    AST_NORM_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now_vec == norm_vec) |=> raw_q[BIT_NHIT]); // R4
    AST_AUX_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && now_vec == aux_vec) |=> raw_q[BIT_AHIT]); // R4
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[BIT_NHIT] && !(bus_we && bus_addr == OFF_CLR && bus_wdata[BIT_NHIT]))
        |=> raw_q[BIT_NHIT]); // R5
    AST_PWR_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |-> (lock_val[KEY_W-1:0] == KEY_OPEN)); // R7
    AST_PWR_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |-> (wake && irq)); // R7
    AST_KEY_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(lock_val)); // R9
endmodule

bind alarm_pair_cmp alarm_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .tick      (tick),
    .now_vec   (now_vec),
    .norm_vec  (norm_vec),
    .aux_vec   (aux_vec),
    .raw_q     (raw_q),
    .lock_val  (lock_val),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wake      (wake),
    .pwr_up    (pwr_up)
);

// File: tb/test_alarm_pair_cmp.sv
module test_alarm_pair_cmp;
    localparam int DLY = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  now_sec = '0;
    logic [5:0]  now_min = '0;
    logic [4:0]  now_hour = '0;
    logic [15:0] now_day = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, wake, pwr_up;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    alarm_pair_cmp #(.COMMIT_DLY(DLY)) i_alarm_pair_cmp (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wake(wake), .pwr_up(pwr_up)
    );

    // Reference model state
    logic [15:0] m_en = 0, m_raw = 0;
    int m_aux[4] = '{0, 0, 0, 0};
    int m_ncmt[4] = '{0, 0, 0, 0};
    int m_stg[4] = '{0, 0, 0, 0};
    int m_cnt[4] = '{0, 0, 0, 0};
    int m_lock = 0, m_lstg = 0, m_lcnt = 0;
    int fmask[4] = '{'h3F, 'h3F, 'h1F, 'hFFFF};

    always @(posedge clk) begin
        logic [15:0] setb, clrb;
        int tnow[4];
        bit nh, ah;
        tnow = '{int'(now_sec), int'(now_min), int'(now_hour), int'(now_day)};
        if (!por_n) begin
            for (int i = 0; i < 4; i++) m_ncmt[i] = 0;
            m_lock = 0;
        end
        if (!rst_n) begin
            m_en = 0; m_raw = 0; m_lcnt = 0; m_lstg = 0;
            for (int i = 0; i < 4; i++) begin m_aux[i] = 0; m_cnt[i] = 0; m_stg[i] = 0; end
        end else begin
            setb = 0;
            nh = tick; ah = tick;
            for (int i = 0; i < 4; i++) begin
                if (tnow[i] != m_ncmt[i]) nh = 0;
                if (tnow[i] != m_aux[i]) ah = 0;
            end
            setb[4] = nh; setb[6] = ah;
            for (int i = 0; i < 4; i++)
                if (m_cnt[i] == 1) begin m_ncmt[i] = m_stg[i]; setb[12 + i] = 1; end
            if (m_lcnt == 1) begin m_lock = m_lstg; setb[7] = 1; end
            for (int i = 0; i < 4; i++) begin
                if (bus_we && bus_addr == 8'(32 + 4 * i)) begin
                    m_cnt[i] = DLY; m_stg[i] = int'(bus_wdata) & fmask[i];
                end else if (m_cnt[i] > 0) m_cnt[i]--;
                if (bus_we && bus_addr == 8'(96 + 4 * i)) m_aux[i] = int'(bus_wdata) & fmask[i];
            end
            if (bus_we && bus_addr == 8'h54) begin m_lcnt = DLY; m_lstg = int'(bus_wdata) & 'h1FF; end
            else if (m_lcnt > 0) m_lcnt--;
            clrb = (bus_we && bus_addr == 8'h38) ? bus_wdata : 16'h0;
            m_raw = (m_raw & ~clrb) | setb;
            if (bus_we && bus_addr == 8'h30) m_en = bus_wdata;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        if (a >= 8'h40 && a <= 8'h4C && a[1:0] == 0) return 16'(m_ncmt[a[3:2]]);
        if (a >= 8'h60 && a <= 8'h6C && a[1:0] == 0) return 16'(m_aux[a[3:2]]);
        case (a)
            8'h30: return m_en;
            8'h34: return m_raw;
            8'h3C: return m_raw & m_en;
            8'h50: return 16'(m_lock);
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of the output lines against the model.
    always @(negedge clk) begin
        chk("R6 irq", irq, |(m_raw & m_en));
        chk("R7 wake", wake, (m_raw[4] & m_en[4]) | (m_raw[6] & m_en[6]));
        chk("R7 pwr_up", pwr_up, m_raw[4] & m_en[4] & (m_lock[7:0] == 8'hA5));
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        @(negedge clk); bus_addr = a; #1;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_time(input int d, input int h, input int m, input int s);
        @(negedge clk);
        now_day = 16'(d); now_hour = 5'(h); now_min = 6'(m); now_sec = 6'(s);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3); por_n = 1'b1; idle(1); rst_n = 1'b1;
        // R1: reset state
        rd("R1 enable", 8'h30); rd("R1 raw", 8'h34); rd("R1 key", 8'h50);
        rd("R1 ncmt", 8'h40); rd("R1 aux", 8'h60);
        chk("R1 irq", irq, 0); chk("R1 pwr_up", pwr_up, 0);

        wr(8'h30, 16'hF0D0);
        // R2: staged primary alarm, boundary tracked every cycle
        wr(8'h20, 16'd5); wr(8'h24, 16'd3); wr(8'h28, 16'd2); wr(8'h2C, 16'd7);
        for (int k = 0; k < DLY + 4; k++) rd("R2 commit sec", 8'h40);
        rd("R2 min", 8'h44); rd("R2 hour", 8'h48); rd("R2 day", 8'h4C);
        rd("R2 done bits", 8'h34);
        chk("R2 day literal", bus_rdata[15:12], 4'hF);

        // R8: key open with power-off flag
        wr(8'h54, 16'h01A5);
        for (int k = 0; k < DLY + 2; k++) rd("R8 key commit", 8'h50);
        chk("R8 key literal", bus_rdata, 16'h01A5);
        rd("R8 lock bit7", 8'h34);

        // R5: partial then full clear
        wr(8'h38, 16'h0080); rd("R5 partial clear", 8'h34);
        wr(8'h38, 16'hFFFF); rd("R5 full clear", 8'h34);

        // R3: secondary alarm immediate, no done bits
        wr(8'h60, 16'd9); rd("R3 sec", 8'h60);
        wr(8'h64, 16'd1); wr(8'h68, 16'd4); wr(8'h6C, 16'd2);
        rd("R3 hour", 8'h68); rd("R3 no done", 8'h34);
        chk("R3 raw literal", bus_rdata, 16'h0000);

        // R4: equal time without tick, then with tick
        set_time(7, 2, 3, 5); idle(4); rd("R4 no tick", 8'h34);
        pulse_tick(); rd("R4 primary hit", 8'h34);
        chk("R7 pwr_up literal", pwr_up, 1'b1);
        // R6: masked view and irq with enable dropped
        wr(8'h30, 16'h0040); rd("R6 masked", 8'h3C); chk("R6 irq off", irq, 1'b0);
        wr(8'h30, 16'hF0D0);
        // R5: set and clear in one cycle, set wins
        @(negedge clk); tick = 1'b1; bus_we = 1'b1; bus_addr = 8'h38; bus_wdata = 16'h0010;
        @(negedge clk); tick = 1'b0; bus_we = 1'b0;
        rd("R5 set wins", 8'h34);
        wr(8'h38, 16'hFFFF);

        // R7: secondary wakes but never powers up
        set_time(2, 4, 1, 9); pulse_tick(); rd("R4 aux hit", 8'h34);
        chk("R7 aux wake", wake, 1'b1); chk("R7 aux no pwr", pwr_up, 1'b0);
        wr(8'h38, 16'hFFFF);

        // R8: close key, primary match no longer powers up
        wr(8'h54, 16'h015A); idle(DLY + 1); rd("R8 key shut", 8'h50);
        set_time(7, 2, 3, 5); pulse_tick();
        chk("R8 shut no pwr", pwr_up, 1'b0); chk("R8 shut wake", wake, 1'b1);
        wr(8'h38, 16'hFFFF);

        // R10: rewrite restarts the commit
        wr(8'h20, 16'd10); idle(DLY / 2); wr(8'h20, 16'd11);
        for (int k = 0; k < DLY + 4; k++) rd("R10 restart", 8'h40);
        chk("R10 literal", bus_rdata, 16'd11);

        // R9: host reset alone
        wr(8'h54, 16'h01A5); idle(DLY + 1);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
        rd("R9 key kept", 8'h50); chk("R9 key literal", bus_rdata, 16'h01A5);
        rd("R9 ncmt kept", 8'h40); rd("R9 day kept", 8'h4C);
        rd("R9 aux cleared", 8'h60); rd("R9 enable cleared", 8'h30);
        rd("R9 raw cleared", 8'h34);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule